// File: doc/BRIEF.md
# Prioritized Interrupt Trap Sequencer

This block sits beside the control unit of a 16-bit minicomputer-style processor. It keeps the pending interrupt requests and decides, at each instruction boundary, whether one of them may interrupt the running program. Each request names a priority level from 0 to 7 and an 8-bit vector. At a given level, all outstanding vectors are held as a set, so a vector raised twice before service is handled once.

When a request is eligible, or when an internal trap such as a bus error is pending, the block runs the trap entry sequence over a simple word-wide memory port. It fetches the new status word from the vector slot. It pushes the old status word and then the old PC onto the stack. Finally it fetches the new PC. At the end it presents the new status word, PC and stack pointer to the processor for one cycle. The new status word is not taken as fetched: its previous-mode field is rebuilt from the old current-mode field. For interrupts, its priority field is also set to the serviced level.

Top module: `trap_sequencer`

## Requirements
- R1: A request (`req_valid` high for one cycle) is added to the set of its level `req_level` (0..7). Raising the same vector at the same level again before service leaves a single pending entry, so that vector is serviced once.
- R2: A pending request is eligible only if its level is strictly greater than the processor priority in `cur_psw[7:5]`. Among eligible levels, the highest is serviced first.
- R3: Within one level, the numerically smallest pending vector is serviced first. A serviced vector is removed from its level.
- R4: A check happens only in a cycle with `boundary` high while `busy` is low, and at most one trap starts per check. A `boundary` pulse while busy has no effect.
- R5: An internal trap latched from `bus_err` (vector 4) or from `trap_req` (vector `trap_vector`) is taken at the next check ahead of all interrupts. For it, the priority bits of the fetched status word are kept as read.
- R6: The trap entry makes exactly four memory operations in consecutive cycles, in this order:
  - read address vector+2;
  - write the old status word at SP-2;
  - write the old PC at SP-4;
  - read address vector+0.
  
  `mem_rdata` is taken in the same cycle as the read request. Vector addresses are the vector zero-extended to 16 bits.
- R7: The new status word is the word read from vector+2 with bits 13:12 cleared, then bits 13:12 set to bits 15:14 of the old status word. For an interrupt, bits 7:5 are then replaced by the serviced level.
- R8: `busy` is high during exactly the four memory-operation cycles. `done` is a one-cycle pulse in the cycle after the last operation. In that cycle `new_psw`, `new_pc` (the word read from vector+0) and `new_sp` (old SP minus 4) are valid. After reset, `busy`, `mem_req` and `done` are low.
- R9: Requests that arrive while a trap sequence is running are kept in their level set and are serviced at a later check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Interrupt request strobe |
| req_level | input | 3 | Priority level of the request |
| req_vector | input | 8 | Vector of the request |
| trap_req | input | 1 | Internal trap strobe |
| trap_vector | input | 8 | Vector of the internal trap |
| bus_err | input | 1 | Bus error, raises an internal trap through vector 4 |
| boundary | input | 1 | Instruction boundary, requests a check |
| cur_psw | input | 16 | Current status word |
| cur_pc | input | 16 | Current PC |
| cur_sp | input | 16 | Current stack pointer |
| busy | output | 1 | Trap sequence in progress |
| mem_req | output | 1 | Memory operation valid |
| mem_we | output | 1 | Memory operation is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the read request |
| done | output | 1 | Trap entry complete, results valid |
| new_psw | output | 16 | Status word to load |
| new_pc | output | 16 | PC to load |
| new_sp | output | 16 | Stack pointer to load |

## Verification
A single request with an all-zero priority is the baseline. It shows the memory order, the stack addresses and how the status word is built, with the old mode bits set to 11. Requests at equal and lower priority, then the same request after the priority is lowered, separate a strict from a non-strict comparison. Two levels queued together, and several vectors queued at one level including a duplicate, separate the level order, the vector order and set semantics. A bus error raised alongside a high-level interrupt shows that internal traps come first and keep the fetched priority bits. Requests and boundary pulses injected mid-sequence show that requests are retained and that checks wait until the sequence is idle.

// File: rtl/trapseq_pkg.sv
package trapseq_pkg;
    localparam int WORD_W      = 16;
    localparam int LEVELS      = 8;
    localparam int VEC_W       = 8;
    localparam int IPL_LSB     = 5;
    localparam int PMODE_LSB   = 12;
    localparam int CMODE_LSB   = 14;
    localparam int MODE_W      = 2;
    localparam logic [WORD_W-1:0] PSW_FETCH_MASK = 16'o147777;
    localparam logic [VEC_W-1:0]  BUS_ERR_VEC    = 8'd4;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH_PSW,
        S_PUSH_PSW,
        S_PUSH_PC,
        S_FETCH_PC
    } seq_state_t;

    typedef struct packed {
        logic                       is_irq;
        logic [$clog2(LEVELS)-1:0]  level;
        logic [VEC_W-1:0]           vector;
    } grant_t;

    function automatic logic [WORD_W-1:0] build_psw(
        input logic [WORD_W-1:0]         fetched,
        input logic [WORD_W-1:0]         old_psw,
        input logic                      is_irq,
        input logic [$clog2(LEVELS)-1:0] lvl
    );
        logic [WORD_W-1:0] p;
        p = fetched & PSW_FETCH_MASK;
        p[PMODE_LSB +: MODE_W] = old_psw[CMODE_LSB +: MODE_W];
        if (is_irq)
            p[IPL_LSB +: $clog2(LEVELS)] = lvl;
        return p;
    endfunction
endpackage

// File: rtl/ts_level_queue.sv
module ts_level_queue
    import trapseq_pkg::*;
#(
    parameter int NLEV  = LEVELS,
    parameter int VW    = VEC_W,
    localparam int LW   = $clog2(NLEV),
    localparam int NV   = 1 << VW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [LW-1:0] push_level,
    input  logic [VW-1:0] push_vec,
    input  logic          pop,
    input  logic [LW-1:0] pop_level,
    input  logic [VW-1:0] pop_vec,
    input  logic [LW-1:0] ipl,
    output logic          any_eligible,
    output logic [LW-1:0] sel_level,
    output logic [VW-1:0] sel_vec
);
    logic [NV-1:0] pend [NLEV];
    logic [NLEV-1:0] nonempty;

    for (genvar g = 0; g < NLEV; g++) begin : g_level
        always_ff @(posedge clk) begin
            if (rst) begin
                pend[g] <= '0;
            end else begin
                if (pop && pop_level == LW'(g))
                    pend[g][pop_vec] <= 1'b0;
                if (push && push_level == LW'(g))
                    pend[g][push_vec] <= 1'b1;
            end
        end
        assign nonempty[g] = |pend[g];
    end

    always_comb begin
        any_eligible = 1'b0;
        sel_level    = '0;
        for (int l = 0; l < NLEV; l++) begin
            if (nonempty[l] && (LW'(l) > ipl)) begin
                any_eligible = 1'b1;
                sel_level    = LW'(l);
            end
        end
    end

    logic [NV-1:0] row;
    assign row = pend[sel_level];

    always_comb begin
        sel_vec = '0;
        for (int v = NV - 1; v >= 0; v--) begin
            if (row[v])
                sel_vec = VW'(v);
        end
    end
endmodule

// File: rtl/ts_entry_engine.sv
module ts_entry_engine
    import trapseq_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int VW = VEC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  grant_t        grant,
    input  logic [W-1:0]  cur_psw,
    input  logic [W-1:0]  cur_pc,
    input  logic [W-1:0]  cur_sp,
    input  logic [W-1:0]  mem_rdata,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    output logic          done,
    output logic [W-1:0]  new_psw,
    output logic [W-1:0]  new_pc,
    output logic [W-1:0]  new_sp
);
    localparam logic [W-1:0] STEP = W'(2);

    seq_state_t   state;
    grant_t       g_q;
    logic [W-1:0] old_psw_q, old_pc_q, sp_q, npsw_q;
    logic [W-1:0] vec_addr;

    assign vec_addr = {{(W-VW){1'b0}}, g_q.vector};

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            g_q       <= '0;
            old_psw_q <= '0;
            old_pc_q  <= '0;
            sp_q      <= '0;
            npsw_q    <= '0;
            done      <= 1'b0;
            new_psw   <= '0;
            new_pc    <= '0;
            new_sp    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        g_q       <= grant;
                        old_psw_q <= cur_psw;
                        old_pc_q  <= cur_pc;
                        sp_q      <= cur_sp;
                        state     <= S_FETCH_PSW;
                    end
                end
                S_FETCH_PSW: begin
                    npsw_q <= build_psw(mem_rdata, old_psw_q, g_q.is_irq, g_q.level);
                    state  <= S_PUSH_PSW;
                end
                S_PUSH_PSW: begin
                    sp_q  <= sp_q - STEP;
                    state <= S_PUSH_PC;
                end
                S_PUSH_PC: begin
                    sp_q  <= sp_q - STEP;
                    state <= S_FETCH_PC;
                end
                S_FETCH_PC: begin
                    new_pc  <= mem_rdata;
                    new_psw <= npsw_q;
                    new_sp  <= sp_q;
                    done    <= 1'b1;
                    state   <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            S_FETCH_PSW: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr + STEP;
            end
            S_PUSH_PSW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - STEP;
                mem_wdata = old_psw_q;
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = sp_q - STEP;
                mem_wdata = old_pc_q;
            end
            S_FETCH_PC: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
            end
            default: ;
        endcase
    end

    assign busy = (state != S_IDLE);
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trapseq_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int NL  = LEVELS,
    parameter int VW  = VEC_W,
    localparam int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [LW-1:0] req_level,
    input  logic [VW-1:0] req_vector,
    input  logic          trap_req,
    input  logic [VW-1:0] trap_vector,
    input  logic          bus_err,
    input  logic          boundary,
    input  logic [W-1:0]  cur_psw,
    input  logic [W-1:0]  cur_pc,
    input  logic [W-1:0]  cur_sp,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [W-1:0]  mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic          done,
    output logic [W-1:0]  new_psw,
    output logic [W-1:0]  new_pc,
    output logic [W-1:0]  new_sp
);
    logic          any_elig;
    logic [LW-1:0] sel_level;
    logic [VW-1:0] sel_vec;
    logic          itrap_pend;
    logic [VW-1:0] itrap_vec;
    logic          start;
    logic          take_itrap;
    grant_t        grant;

    assign start      = boundary && !busy && (itrap_pend || any_elig);
    assign take_itrap = start && itrap_pend;

    always_comb begin
        grant = '0;
        if (itrap_pend) begin
            grant.is_irq = 1'b0;
            grant.vector = itrap_vec;
        end else begin
            grant.is_irq = 1'b1;
            grant.level  = sel_level;
            grant.vector = sel_vec;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            itrap_pend <= 1'b0;
            itrap_vec  <= '0;
        end else begin
            if (take_itrap)
                itrap_pend <= 1'b0;
            if ((bus_err || trap_req) && (!itrap_pend || take_itrap)) begin
                itrap_pend <= 1'b1;
                itrap_vec  <= bus_err ? BUS_ERR_VEC : trap_vector;
            end
        end
    end

    ts_level_queue #(.NLEV(NL), .VW(VW)) u_queue (
        .clk         (clk),
        .rst         (rst),
        .push        (req_valid),
        .push_level  (req_level),
        .push_vec    (req_vector),
        .pop         (start && !itrap_pend),
        .pop_level   (sel_level),
        .pop_vec     (sel_vec),
        .ipl         (cur_psw[IPL_LSB +: LW]),
        .any_eligible(any_elig),
        .sel_level   (sel_level),
        .sel_vec     (sel_vec)
    );

    ts_entry_engine #(.W(W), .VW(VW)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .grant     (grant),
        .cur_psw   (cur_psw),
        .cur_pc    (cur_pc),
        .cur_sp    (cur_sp),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done),
        .new_psw   (new_psw),
        .new_pc    (new_pc),
        .new_sp    (new_sp)
    );
endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         boundary,
    input logic         busy,
    input logic         mem_req,
    input logic         mem_we,
    input logic [W-1:0] mem_addr,
    input logic         done
);
    a_r8_mem_only_busy: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    a_r6_first_op_read: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (mem_req && !mem_we));

    a_r6_push_predecrement: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - W'(2)));

    a_r8_done_on_finish: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r4_start_needs_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(boundary));
endmodule

bind trap_sequencer trap_sequencer_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .boundary(boundary),
    .busy    (busy),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_addr(mem_addr),
    .done    (done)
);

// File: tb/tb_trap_sequencer.sv
`timescale 1ns/1ps
module tb_trap_sequencer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_level = '0;
    logic [7:0]  req_vector = '0;
    logic        trap_req = 1'b0;
    logic [7:0]  trap_vector = '0;
    logic        bus_err = 1'b0;
    logic        boundary = 1'b0;
    logic [15:0] cur_psw = '0, cur_pc = '0, cur_sp = '0;
    logic        busy, mem_req, mem_we, done;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, new_psw, new_pc, new_sp;

    always #5 clk = ~clk;

    function automatic logic [15:0] memval(input logic [15:0] a);
        return (a * 16'h0123) ^ 16'hF0A5;
    endfunction
    assign mem_rdata = memval(mem_addr);

    trap_sequencer dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
        .req_vector(req_vector), .trap_req(trap_req), .trap_vector(trap_vector),
        .bus_err(bus_err), .boundary(boundary), .cur_psw(cur_psw), .cur_pc(cur_pc),
        .cur_sp(cur_sp), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .new_psw(new_psw), .new_pc(new_pc), .new_sp(new_sp)
    );

    typedef struct {
        int          kind;   // 0 read, 1 write, 2 done
        logic [15:0] addr;
        logic [15:0] data;
        logic [15:0] psw;
        logic [15:0] pc;
        logic [15:0] sp;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_trap(input logic [7:0] vec, input bit irq, input logic [2:0] lvl,
                               input string tag);
        exp_t e;
        logic [15:0] va, p;
        va = {8'h00, vec};
        p  = (memval(va + 16'd2) & 16'hCFFF) | ((cur_psw >> 2) & 16'h3000);
        if (irq) p = (p & ~16'h00E0) | (16'(lvl) << 5);
        e = '{0, va + 16'd2, 16'h0, 16'h0, 16'h0, 16'h0, {tag, " R6 fetch psw"}};
        exp_q.push_back(e);
        e = '{1, cur_sp - 16'd2, cur_psw, 16'h0, 16'h0, 16'h0, {tag, " R6 push psw"}};
        exp_q.push_back(e);
        e = '{1, cur_sp - 16'd4, cur_pc, 16'h0, 16'h0, 16'h0, {tag, " R6 push pc"}};
        exp_q.push_back(e);
        e = '{0, va, 16'h0, 16'h0, 16'h0, 16'h0, {tag, " R6 fetch pc"}};
        exp_q.push_back(e);
        e = '{2, 16'h0, 16'h0, p, memval(va), cur_sp - 16'd4, {tag, " R7 R8 result"}};
        exp_q.push_back(e);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && (mem_req || done)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R4 unexpected activity", mem_addr, 16'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (done) begin
                    chk(e.kind == 2, {e.tag, " kind"}, 16'd2, 16'(e.kind));
                    chk(new_psw == e.psw, {e.tag, " new_psw"}, new_psw, e.psw);
                    chk(new_pc == e.pc, {e.tag, " new_pc"}, new_pc, e.pc);
                    chk(new_sp == e.sp, {e.tag, " new_sp"}, new_sp, e.sp);
                end else begin
                    chk(e.kind == int'(mem_we), {e.tag, " op kind"}, 16'(mem_we), 16'(e.kind));
                    chk(mem_addr == e.addr, {e.tag, " addr"}, mem_addr, e.addr);
                    if (mem_we)
                        chk(mem_wdata == e.data, {e.tag, " wdata"}, mem_wdata, e.data);
                end
            end
        end
    end

    task automatic push_req(input logic [2:0] lvl, input logic [7:0] vec);
        @(negedge clk);
        req_valid = 1'b1; req_level = lvl; req_vector = vec;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_boundary();
        @(negedge clk);
        boundary = 1'b1;
        @(negedge clk);
        boundary = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic expect_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!busy && !mem_req, tag, 16'(busy), 16'h0);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_req && !done, "R8 reset state", {13'h0, busy, mem_req, done}, 16'h0);

        // T1: baseline interrupt, old mode 11
        cur_psw = 16'hC000; cur_pc = 16'h1000; cur_sp = 16'h2000;
        push_req(3'd5, 8'o220);
        expect_trap(8'o220, 1'b1, 3'd5, "R1 R7 single");
        pulse_boundary();
        drain();

        // T2: strict comparison
        cur_psw = 16'h0080; cur_pc = 16'h1100; cur_sp = 16'h3000;
        push_req(3'd4, 8'h40);
        pulse_boundary();
        expect_idle(6, "R2 equal level not taken");
        cur_psw = 16'h4060;
        expect_trap(8'h40, 1'b1, 3'd4, "R2 higher level taken");
        pulse_boundary();
        drain();

        // T3: highest level first, one trap per check
        cur_psw = 16'h0000; cur_pc = 16'h1200; cur_sp = 16'h3400;
        push_req(3'd3, 8'h30);
        push_req(3'd6, 8'h34);
        expect_trap(8'h34, 1'b1, 3'd6, "R2 highest first");
        pulse_boundary();
        drain();
        expect_idle(4, "R4 one trap per check");
        expect_trap(8'h30, 1'b1, 3'd3, "R2 lower after");
        pulse_boundary();
        drain();

        // T4: smallest vector first, duplicate once
        cur_pc = 16'h1300; cur_sp = 16'h3800;
        push_req(3'd2, 8'h50);
        push_req(3'd2, 8'h24);
        push_req(3'd2, 8'h50);
        expect_trap(8'h24, 1'b1, 3'd2, "R3 smallest vector");
        pulse_boundary();
        drain();
        expect_trap(8'h50, 1'b1, 3'd2, "R3 next vector");
        pulse_boundary();
        drain();
        pulse_boundary();
        expect_idle(6, "R1 duplicate serviced once");

        // T5: bus error ahead of interrupts
        cur_psw = 16'h8000; cur_pc = 16'h1400; cur_sp = 16'h3C00;
        push_req(3'd7, 8'h10);
        @(negedge clk); bus_err = 1'b1;
        @(negedge clk); bus_err = 1'b0;
        expect_trap(8'd4, 1'b0, 3'd0, "R5 bus error first");
        pulse_boundary();
        drain();
        expect_trap(8'h10, 1'b1, 3'd7, "R5 then interrupt");
        pulse_boundary();
        drain();

        // T5b: software internal trap
        @(negedge clk); trap_req = 1'b1; trap_vector = 8'h1C;
        @(negedge clk); trap_req = 1'b0;
        expect_trap(8'h1C, 1'b0, 3'd0, "R5 internal trap");
        pulse_boundary();
        drain();

        // T6: request during busy retained; boundary during busy ignored
        cur_psw = 16'h0000; cur_pc = 16'h1500; cur_sp = 16'h4000;
        push_req(3'd1, 8'h60);
        expect_trap(8'h60, 1'b1, 3'd1, "R9 first");
        pulse_boundary();
        push_req(3'd6, 8'h64);
        pulse_boundary();
        drain();
        expect_idle(3, "R4 boundary while busy ignored");
        expect_trap(8'h64, 1'b1, 3'd6, "R9 retained request");
        pulse_boundary();
        drain();

        chk(exp_q.size() == 0, "R6 all expected operations seen", 16'(exp_q.size()), 16'h0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule